// File: doc/BRIEF.md
# Lockable Non-Maskable Interrupt Edge Detector

This block turns an asynchronous external pin into a non-maskable interrupt request wired straight to a processor core. The core's interrupt controller never sees it. The pin is first brought into the clock domain by a short synchronizer chain. A detector then compares each synchronized sample with the one before it and looks for the edge kind that software selected: rising, falling or either.

Software sets the edge kind once, through a two-bit write port. The first write of a nonzero kind latches that kind and sets a sticky lock. From then on the configuration cannot be changed or turned off until reset. The lock state and the active kind can be read back on output ports.

Every qualifying edge sets a pending flag, which drives the request output. No mask of any kind can hold the request back. The core clears the flag with a one-cycle acknowledge. If a fresh edge lands in the same cycle as the acknowledge, the flag stays set, so that edge is not lost.

Top module: `nmi_edge_lock`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `nmi_req` is 0, `cfg_locked` is 0 and `cfg_mode` is 2'b00.
- R2: With the default two synchronizer stages, a pin change that is stable before clock edge 1 sets `nmi_req` at clock edge 3. The request is still 0 after edge 2.
- R3: Mode 2'b01 (bit 0 = rising) raises the request on a 0-to-1 pin transition only. A 1-to-0 transition leaves `nmi_req` at 0.
- R4: Mode 2'b10 (bit 1 = falling) raises the request on a 1-to-0 pin transition only. A 0-to-1 transition leaves `nmi_req` at 0.
- R5: Mode 2'b11 raises the request on a transition in either direction.
- R6: In mode 2'b00 no pin transition raises the request. A write of 2'b00 leaves `cfg_locked` at 0 and `cfg_mode` at 2'b00.
- R7: A write (`cfg_wr_en` high) of a nonzero value while unlocked loads `cfg_mode` with that value and sets `cfg_locked` at the same clock edge.
- R8: Once `cfg_locked` is 1, it stays 1 until reset. Further writes, including 2'b00, change neither `cfg_mode` nor the detection behaviour.
- R9: `nmi_req` stays set, with no time limit, until `nmi_ack` is sampled high with no coinciding edge. It is then 0 after that clock edge.
- R10: If a qualifying edge is detected in the same cycle that `nmi_ack` is high, `nmi_req` remains 1 after that clock edge.
- R11: No input except reset and acknowledge clears or suppresses a set request. A configuration write while the request is pending leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | External interrupt pin, asynchronous to clk |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 2 | Edge kind to write: 00 off, 01 rising, 10 falling, 11 both |
| cfg_mode | output | 2 | Active edge kind |
| cfg_locked | output | 1 | Sticky lock status |
| nmi_ack | input | 1 | One-cycle acknowledge from the core |
| nmi_req | output | 1 | Interrupt request to the core |

## Verification
The pin is driven with:
- isolated rising and falling transitions under each of the four edge kinds;
- rewrites after the lock is set;
- a configuration write while a request is pending;
- an acknowledge placed exactly on the cycle where a second edge is detected.

The paired rise/fall patterns separate the direction decoding of each mode bit. Sampling after two and after three clock edges pins the synchronizer latency. The coinciding acknowledge separates "set wins" from "clear wins" in the pending flag. Readback of the mode after forbidden writes tells a frozen register from one that only ignores the value.

// File: rtl/nmi_pkg.sv
// Shared types for the lockable NMI edge detector.
// Assumes: bit 0 of a mode selects rising edges, bit 1 selects falling edges.
package nmi_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/nmi_sync.sv
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes: the input is a slow level signal; every stage resets to 0.
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the pin value through the chain of flops.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/nmi_cfg.sv
// Write-once configuration register: the first nonzero write latches the mode
// and sets a sticky lock; later writes are dropped until reset.
// Assumes: writes are single-cycle strobes in the clk domain.
module nmi_cfg
    import nmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output edge_mode_e        mode,
    output logic              locked
);
    logic take;
    assign take = wr_en && !locked && (wr_data != EDGE_OFF);

    // Latch the first nonzero mode and freeze it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= EDGE_OFF;
            locked <= 1'b0;
        end else if (take) begin
            mode   <= edge_mode_e'(wr_data);
            locked <= 1'b1;
        end
    end

    // R8: lock is sticky until reset
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    // R8: mode frozen while locked
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode));
    // R7: a nonzero write always leaves the block locked
    p_nonzero_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != EDGE_OFF) |=> locked);
    // R6: while unlocked, a mode other than off never appears
    p_off_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> mode == EDGE_OFF);
endmodule

// File: rtl/nmi_edge.sv
// Edge detector and pending flag. It compares the synchronized level with the
// previous sample, qualifies the result by mode, and holds a request until it
// is acknowledged. A new edge wins over an acknowledge in the same cycle.
// Assumes: ack is a single-cycle pulse from the core.
module nmi_edge
    import nmi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  edge_mode_e mode,
    input  logic       ack,
    output logic       pending
);
    logic prev;
    logic hit;

    // Qualify a rise by mode bit 0 and a fall by mode bit 1.
    always_comb begin
        hit = (mode[0] & lvl & ~prev) | (mode[1] & ~lvl & prev);
    end

    // Remember the previous sample and update the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev    <= 1'b0;
            pending <= 1'b0;
        end else begin
            prev    <= lvl;
            pending <= hit | (pending & ~ack);
        end
    end

    // R10: a detected edge always leaves the flag set
    p_edge_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pending);
    // R9: acknowledge without an edge clears
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !pending);
    // R11: nothing but acknowledge drops a pending request
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    // R6: the flag only rises after a qualified edge
    p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(hit));
endmodule

// File: rtl/nmi_edge_lock.sv
// Top of the lockable NMI edge detector: synchronizer, write-once
// configuration and edge/pending logic. The request goes directly to the core.
// Assumes: pin_async is asynchronous; all other inputs are in the clk domain.
module nmi_edge_lock
    import nmi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_async,
    input  logic              cfg_wr_en,
    input  logic [MODE_W-1:0] cfg_wr_data,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_locked,
    input  logic              nmi_ack,
    output logic              nmi_req
);
    logic       pin_lvl;
    edge_mode_e mode_q;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_async),
        .dout (pin_lvl)
    );

    nmi_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_data(cfg_wr_data),
        .mode   (mode_q),
        .locked (cfg_locked)
    );

    nmi_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (pin_lvl),
        .mode   (mode_q),
        .ack    (nmi_ack),
        .pending(nmi_req)
    );

    assign cfg_mode = mode_q;

    // R1: reset clears request and lock at the next edge
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!nmi_req && !cfg_locked && cfg_mode == 2'b00));
endmodule

// File: tb/tb_nmi_edge_lock.sv
`timescale 1ns/1ps
module tb_nmi_edge_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_data = 2'b00;
    logic [1:0] cfg_mode;
    logic       cfg_locked;
    logic       nmi_ack = 1'b0;
    logic       nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic       req;
        logic       lck;
        logic [1:0] mode;
    } exp_t;

    exp_t q[$];
    exp_t cur;

    always #4 clk = ~clk;

    nmi_edge_lock dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_mode(cfg_mode), .cfg_locked(cfg_locked),
        .nmi_ack(nmi_ack), .nmi_req(nmi_req)
    );

    // Monitor: pop expected items and compare at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            cur = q.pop_front();
            checks++;
            if (nmi_req !== cur.req || cfg_locked !== cur.lck || cfg_mode !== cur.mode) begin
                errors++;
                $display("FAIL %s: actual req=%b lock=%b mode=%b expected req=%b lock=%b mode=%b",
                         cur.tag, nmi_req, cfg_locked, cfg_mode, cur.req, cur.lck, cur.mode);
            end
        end
    end

    // Driver side: queue an expectation just after a rising edge.
    task automatic expect_st(string tag, logic req, logic lck, logic [1:0] mode);
        exp_t e;
        e.tag = tag; e.req = req; e.lck = lck; e.mode = mode;
        q.push_back(e);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_async = 1'b0; cfg_wr_en = 1'b0; nmi_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(logic [1:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_pin(logic v);
        @(negedge clk);
        pin_async = v;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        nmi_ack = 1'b1;
        @(negedge clk);
        nmi_ack = 1'b0;
    endtask

    initial begin
        do_reset();
        edges(1); expect_st("R1 reset", 0, 0, 2'b00);

        // Off mode: a zero write does not lock, pin activity is ignored.
        write_cfg(2'b00);
        edges(1); expect_st("R6 zero write", 0, 0, 2'b00);
        set_pin(1); edges(4); expect_st("R6 off rise", 0, 0, 2'b00);
        set_pin(0); edges(4); expect_st("R6 off fall", 0, 0, 2'b00);

        // Rising mode.
        write_cfg(2'b01);
        edges(1); expect_st("R7 lock on write", 0, 1, 2'b01);
        set_pin(1); edges(2); expect_st("R2 not yet", 0, 1, 2'b01);
        edges(1); expect_st("R2 R3 rise seen", 1, 1, 2'b01);
        edges(5); expect_st("R9 held", 1, 1, 2'b01);
        pulse_ack(); edges(1); expect_st("R9 ack clears", 0, 1, 2'b01);
        set_pin(0); edges(4); expect_st("R3 fall ignored", 0, 1, 2'b01);
        write_cfg(2'b11);
        edges(1); expect_st("R8 rewrite ignored", 0, 1, 2'b01);
        set_pin(1); edges(4); expect_st("R8 still rising", 1, 1, 2'b01);
        set_pin(0); edges(4);
        write_cfg(2'b00);
        edges(1); expect_st("R11 write keeps req", 1, 1, 2'b01);
        pulse_ack(); edges(1); expect_st("R9 ack after write", 0, 1, 2'b01);

        // Falling mode.
        do_reset();
        edges(1); expect_st("R1 reset again", 0, 0, 2'b00);
        write_cfg(2'b10);
        set_pin(1); edges(4); expect_st("R4 rise ignored", 0, 1, 2'b10);
        set_pin(0); edges(3); expect_st("R4 fall seen", 1, 1, 2'b10);
        pulse_ack(); edges(1); expect_st("R9 ack falling", 0, 1, 2'b10);

        // Both mode, then an edge coinciding with acknowledge.
        do_reset();
        write_cfg(2'b11);
        set_pin(1); edges(3); expect_st("R5 rise", 1, 1, 2'b11);
        pulse_ack(); edges(1); expect_st("R9 ack both", 0, 1, 2'b11);
        set_pin(0); edges(3); expect_st("R5 fall", 1, 1, 2'b11);
        // Edge detected in the cycle before edge 3; ack high across edge 3.
        set_pin(1);
        repeat (2) @(posedge clk);
        @(negedge clk); nmi_ack = 1'b1;
        @(negedge clk); nmi_ack = 1'b0;
        edges(1); expect_st("R10 edge beats ack", 1, 1, 2'b11);
        pulse_ack(); edges(1); expect_st("R9 final ack", 0, 1, 2'b11);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule